// File: doc/BRIEF.md
# Temperature-Indexed Setting Lookup Controller

This controller turns a periodic temperature reading into an index into two 72-entry setting tables, one table per output channel. It then copies the two entries at that index into two 8-bit setting registers. The index steps once every 2 °C, starting at -40 °C. A 1 °C hysteresis band keeps the index from chattering when the temperature sits near a step boundary. The controller reads the tables through a single synchronous read port with a one-cycle latency. Both setting registers take their new values on the same clock edge.

Temperature words arrive on a valid/ready stream. Back-pressure rules:
- Ready is low while a table fetch is running.
- Ready is low while the host bus is busy (`bus_busy` high).
- Ready is low while a direct index write is being taken.
- The producer must hold the word, with valid high, until a cycle in which ready is high.

Two plain control inputs change the mode of operation:
- Clearing `upd_en` gives manual mode. Temperature no longer drives anything, and the host writes the settings directly.
- Clearing `idx_auto` gives test mode. The index is frozen against temperature, and a direct index write loads the two table entries at the written index.

A flag, `tau`, reports that a temperature-driven load has completed. The host may clear it.

Top module: `temp_lut_ctrl`

## Requirements
- R1: The temperature is the 13-bit two's-complement field `temp_data[15:3]`, in units of 1/16 °C. Bits [2:0] are ignored. The raw step is floor((T + 40 °C) / 2 °C), so the step changes at -40 °C plus every multiple of 2 °C.
- R2: Any computed index below 0 becomes 0, and any computed index above 71 becomes 71. The index output never exceeds 71.
- R3: The first accepted reading after reset with both `upd_en` and `idx_auto` high sets the index to its raw step directly, whatever the current index is.
- R4: After that first reading, the index follows these rules:
  - If the raw step is greater than or equal to the current index, the index becomes the raw step.
  - Otherwise, if floor((T + 41 °C) / 2 °C) is below the current index, the index becomes that value (after clamping).
  - Otherwise the index stays the same.
  - As a result, falling thresholds lie 1 °C below rising thresholds.
- R5: A table load reads table 0 (`rd_sel`=0) in the first cycle after the load starts and table 1 (`rd_sel`=1) in the second cycle, both at the current index. Read data returns one cycle after each read. Both setting registers update together on the third rising edge after the start edge.
- R6: `tau` goes to 1 when a temperature-started load completes. `tau_clr` clears it to 0. If both happen on the same edge, setting wins.
- R7: With `upd_en`=0, temperature words are still accepted but are discarded. They leave the index, the settings and `tau` unchanged. In this mode `set0_wr` and `set1_wr` load `set_wdata` into setting 0 or setting 1. With `upd_en`=1 those two writes are ignored.
- R8: With `idx_auto`=0, a temperature word accepted while `upd_en`=1 leaves the index unchanged. It still reloads both settings from the frozen index and sets `tau`.
- R8 (continued): With `idx_auto`=0, `idx_wr` while no load is running sets the index to `idx_wdata`, with values above 71 taken as 71. It then loads both settings at that index and leaves `tau` unchanged.
- R8 (continued): With `idx_auto`=1, `idx_wr` is ignored.
- R9: `temp_ready` is high only when no load is running, `bus_busy` is low, and no index write is being taken in that cycle. A word is consumed only on a cycle where both `temp_valid` and `temp_ready` are high.
- R10: Reset sets the index to 0, both settings to 0 and `tau` to 0, and issues no table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | Temperature word valid |
| temp_ready | output | 1 | Temperature word accepted when high together with valid |
| temp_data | input | 16 | Temperature word: [15:3] two's complement in 1/16 °C; [2:0] ignored |
| bus_busy | input | 1 | Host bus access in progress; blocks temperature acceptance |
| upd_en | input | 1 | Temperature-driven updates enabled (0 = manual mode) |
| idx_auto | input | 1 | Index follows temperature (0 = test mode) |
| idx_wr | input | 1 | Direct index write strobe (test mode only) |
| idx_wdata | input | 7 | Direct index value |
| set0_wr | input | 1 | Direct write strobe for setting 0 (manual mode only) |
| set1_wr | input | 1 | Direct write strobe for setting 1 (manual mode only) |
| set_wdata | input | 8 | Direct setting value |
| tau_clr | input | 1 | Clears the load-done flag |
| rd_en | output | 1 | Table read request |
| rd_sel | output | 1 | Table select: 0 = table 0, 1 = table 1 |
| rd_addr | output | 7 | Table entry address |
| rd_data | input | 8 | Table read data, one cycle after the request |
| index | output | 7 | Current table index |
| setting0 | output | 8 | Setting register for channel 0 |
| setting1 | output | 8 | Setting register for channel 1 |
| tau | output | 1 | Temperature-driven load completed |

## Verification
A wrong hysteresis decision or a wrong clamp appears on `index` one edge after the word is accepted. A bad read sequence shows up three edges later as a wrong pair of values on `setting0` and `setting1`. A controller that stays busy, or that ignores `bus_busy`, shows as `temp_ready` differing from the model in the very cycle concerned. Because the model is compared on every clock, each of these faults is reported no later than the edge where it would first become visible to a host.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_RD0,
    FS_RD1,
    FS_CAP
  } fetch_st_t;
endpackage

// File: rtl/temp_index_calc.sv
module temp_index_calc #(
  parameter int TW      = 13,
  parameter int IW      = 7,
  parameter int ENTRIES = 72,
  parameter int OFF_Q   = 640,
  parameter int HYST_Q  = 16,
  parameter int STEP_SH = 5
) (
  input  logic [TW-1:0] temp_q,
  input  logic [IW-1:0] cur_idx,
  input  logic          seen,
  output logic [IW-1:0] nxt_idx
);
  localparam int WW = TW + 3;
  localparam logic signed [WW-1:0] OFF_LO = WW'(OFF_Q);
  localparam logic signed [WW-1:0] OFF_HI = WW'(OFF_Q + HYST_Q);
  localparam logic signed [WW-1:0] MAX_S  = WW'(ENTRIES - 1);

  function automatic logic [IW-1:0] clip(input logic signed [WW-1:0] v);
    if (v < 0)          return '0;
    else if (v > MAX_S) return IW'(ENTRIES - 1);
    else                return v[IW-1:0];
  endfunction

  logic signed [WW-1:0] t_ext, lo_s, hi_s, cur_s;
  logic [IW-1:0] lo_i, hi_i;

  always_comb begin
    t_ext = {{(WW-TW){temp_q[TW-1]}}, temp_q};
    lo_s  = (t_ext + OFF_LO) >>> STEP_SH;
    hi_s  = (t_ext + OFF_HI) >>> STEP_SH;
    cur_s = WW'(cur_idx);
    lo_i  = clip(lo_s);
    hi_i  = clip(hi_s);
    if (!seen || lo_s >= cur_s) nxt_idx = lo_i;
    else if (hi_i < cur_idx)    nxt_idx = hi_i;
    else                        nxt_idx = cur_idx;
  end
endmodule

// File: rtl/lut_fetch_seq.sv
module lut_fetch_seq
  import tlc_pkg::*;
#(
  parameter int IW = 7,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] addr,
  output logic          idle,
  output logic          rd_en,
  output logic          rd_sel,
  output logic [IW-1:0] rd_addr,
  input  logic [SW-1:0] rd_data,
  output logic          done,
  output logic [SW-1:0] d0,
  output logic [SW-1:0] d1
);
  fetch_st_t st;
  logic [SW-1:0] hold0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= FS_IDLE;
      hold0 <= '0;
    end else begin
      case (st)
        FS_IDLE: if (start) st <= FS_RD0;
        FS_RD0:  st <= FS_RD1;
        FS_RD1: begin
          hold0 <= rd_data;
          st    <= FS_CAP;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign idle    = (st == FS_IDLE);
  assign rd_en   = (st == FS_RD0) || (st == FS_RD1);
  assign rd_sel  = (st == FS_RD1);
  assign rd_addr = addr;
  assign done    = (st == FS_CAP);
  assign d0      = hold0;
  assign d1      = rd_data;
endmodule

// File: rtl/temp_lut_ctrl.sv
module temp_lut_ctrl #(
  parameter int TEMP_W  = 13,
  parameter int PAD_W   = 3,
  parameter int ENTRIES = 72,
  parameter int IDX_W   = 7,
  parameter int SET_W   = 8,
  parameter int BASE_C  = 40,
  parameter int FRAC_SH = 4,
  parameter int STEP_C  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      temp_valid,
  output logic                      temp_ready,
  input  logic [TEMP_W+PAD_W-1:0]   temp_data,
  input  logic                      bus_busy,
  input  logic                      upd_en,
  input  logic                      idx_auto,
  input  logic                      idx_wr,
  input  logic [IDX_W-1:0]          idx_wdata,
  input  logic                      set0_wr,
  input  logic                      set1_wr,
  input  logic [SET_W-1:0]          set_wdata,
  input  logic                      tau_clr,
  output logic                      rd_en,
  output logic                      rd_sel,
  output logic [IDX_W-1:0]          rd_addr,
  input  logic [SET_W-1:0]          rd_data,
  output logic [IDX_W-1:0]          index,
  output logic [SET_W-1:0]          setting0,
  output logic [SET_W-1:0]          setting1,
  output logic                      tau
);
  localparam int OFF_Q   = BASE_C << FRAC_SH;
  localparam int HYST_Q  = 1 << FRAC_SH;
  localparam int STEP_SH = FRAC_SH + $clog2(STEP_C);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] nxt_idx, wr_idx;
  logic seen, tflag, seq_idle, seq_done, acc_t, acc_i, start;
  logic [SET_W-1:0] d0, d1;

  temp_index_calc #(
    .TW(TEMP_W), .IW(IDX_W), .ENTRIES(ENTRIES),
    .OFF_Q(OFF_Q), .HYST_Q(HYST_Q), .STEP_SH(STEP_SH)
  ) u_calc (
    .temp_q (temp_data[TEMP_W+PAD_W-1:PAD_W]),
    .cur_idx(index),
    .seen   (seen),
    .nxt_idx(nxt_idx)
  );

  lut_fetch_seq #(.IW(IDX_W), .SW(SET_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(index),
    .idle(seq_idle), .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(seq_done), .d0(d0), .d1(d1)
  );

  assign acc_i      = idx_wr && !idx_auto && seq_idle;
  assign temp_ready = seq_idle && !bus_busy && !(idx_wr && !idx_auto);
  assign acc_t      = temp_valid && temp_ready;
  assign start      = acc_i || (acc_t && upd_en);
  assign wr_idx     = (idx_wdata > IDX_MAX) ? IDX_MAX : idx_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index    <= '0;
      setting0 <= '0;
      setting1 <= '0;
      tau      <= 1'b0;
      seen     <= 1'b0;
      tflag    <= 1'b0;
    end else begin
      if (acc_i) begin
        index <= wr_idx;
        tflag <= 1'b0;
      end else if (acc_t && upd_en) begin
        tflag <= 1'b1;
        if (idx_auto) begin
          index <= nxt_idx;
          seen  <= 1'b1;
        end
      end
      if (seq_done) begin
        setting0 <= d0;
        setting1 <= d1;
      end else if (!upd_en) begin
        if (set0_wr) setting0 <= set_wdata;
        if (set1_wr) setting1 <= set_wdata;
      end
      if (seq_done && tflag) tau <= 1'b1;
      else if (tau_clr)      tau <= 1'b0;
    end
  end
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
  parameter int IW      = 7,
  parameter int ENTRIES = 72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          temp_ready,
  input logic          bus_busy,
  input logic          idx_auto,
  input logic          idx_wr,
  input logic [IW-1:0] index,
  input logic          rd_en,
  input logic          rd_sel,
  input logic [IW-1:0] rd_addr
);
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    index <= IW'(ENTRIES - 1));

  assert_rd_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel) |=> (rd_en && rd_sel));

  assert_rd_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr == index));

  assert_frozen_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(idx_auto) && !$past(idx_wr)) |-> $stable(index));

  assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !temp_ready);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |-> !rd_en);
endmodule

bind temp_lut_ctrl tlc_checker #(.IW(IDX_W), .ENTRIES(ENTRIES)) u_tlc_chk (
  .clk(clk), .rst_n(rst_n), .temp_ready(temp_ready), .bus_busy(bus_busy),
  .idx_auto(idx_auto), .idx_wr(idx_wr), .index(index),
  .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr)
);

// File: tb/test_temp_lut_ctrl.sv
`timescale 1ns/1ps
module test_temp_lut_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic temp_valid = 1'b0, bus_busy = 1'b0, upd_en = 1'b1, idx_auto = 1'b1;
  logic idx_wr = 1'b0, set0_wr = 1'b0, set1_wr = 1'b0, tau_clr = 1'b0;
  logic [15:0] temp_data = '0;
  logic [6:0] idx_wdata = '0;
  logic [7:0] set_wdata = '0, rd_data = '0;
  logic temp_ready, rd_en, rd_sel, tau;
  logic [6:0] rd_addr, index;
  logic [7:0] setting0, setting1;

  always #2.5 clk = ~clk;

  temp_lut_ctrl i_temp_lut_ctrl (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_ready(temp_ready),
    .temp_data(temp_data), .bus_busy(bus_busy), .upd_en(upd_en), .idx_auto(idx_auto),
    .idx_wr(idx_wr), .idx_wdata(idx_wdata), .set0_wr(set0_wr), .set1_wr(set1_wr),
    .set_wdata(set_wdata), .tau_clr(tau_clr), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_addr(rd_addr), .rd_data(rd_data), .index(index), .setting0(setting0),
    .setting1(setting1), .tau(tau)
  );

  int tbl0[72];
  int tbl1[72];
  initial for (int i = 0; i < 72; i++) begin
    tbl0[i] = (i * 7 + 3) % 256;
    tbl1[i] = 255 - 3 * i;
  end

  always @(posedge clk) if (rd_en) rd_data <= 8'(rd_sel ? tbl1[rd_addr] : tbl0[rd_addr]);

  int vectors = 0, fails = 0, cycles = 0;
  string tag = "R10";
  int m_idx = 0, m_s0 = 0, m_s1 = 0, m_tau = 0, m_cnt = 0, m_seen = 0, m_tflag = 0;
  bit done_flag = 0;

  function automatic int clampi(int v);
    if (v < 0) return 0;
    if (v > 71) return 71;
    return v;
  endfunction

  function automatic int calc(int tc, int cur, int seen);
    int lo, hi;
    lo = (tc + 640) >>> 5;
    hi = (tc + 656) >>> 5;
    if (seen == 0 || lo >= cur) return clampi(lo);
    if (clampi(hi) < cur) return clampi(hi);
    return cur;
  endfunction

  function automatic int tc_of(logic [15:0] w);
    logic signed [12:0] s;
    s = w[15:3];
    return int'(s);
  endfunction

  function automatic bit m_ready();
    return (m_cnt == 0) && !bus_busy && !(idx_wr && !idx_auto);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_s0 = 0; m_s1 = 0; m_tau = 0; m_cnt = 0; m_seen = 0; m_tflag = 0;
    end else begin
      bit acc_t, acc_i, commit;
      acc_t = temp_valid && m_ready();
      acc_i = idx_wr && !idx_auto && (m_cnt == 0);
      commit = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) commit = 1;
      end
      if (commit) begin
        m_s0 = tbl0[m_idx]; m_s1 = tbl1[m_idx];
      end else if (!upd_en) begin
        if (set0_wr) m_s0 = set_wdata;
        if (set1_wr) m_s1 = set_wdata;
      end
      if (commit && m_tflag) m_tau = 1;
      else if (tau_clr) m_tau = 0;
      if (acc_i) begin
        m_idx = idx_wdata > 71 ? 71 : int'(idx_wdata);
        m_cnt = 3; m_tflag = 0;
      end else if (acc_t && upd_en) begin
        if (idx_auto) begin
          m_idx = calc(tc_of(temp_data), m_idx, m_seen);
          m_seen = 1;
        end
        m_cnt = 3; m_tflag = 1;
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done_flag) begin
      vectors++;
      cmp("index", index, m_idx);
      cmp("setting0", setting0, m_s0);
      cmp("setting1", setting1, m_s1);
      cmp("tau", tau, m_tau);
      cmp("temp_ready", temp_ready, m_ready());
    end
    if (cycles > 100000 && !done_flag) begin
      fails++;
      $display("FAIL watchdog actual %0d expected 0", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_temp(int tc);
    @(posedge clk); #1;
    temp_valid = 1'b1;
    temp_data  = 16'(tc * 8) | 16'h0005;
    @(negedge clk);
    while (!temp_ready) @(negedge clk);
    @(posedge clk); #1;
    temp_valid = 1'b0;
    settle();
  endtask

  task automatic write_idx(int v);
    @(posedge clk); #1; idx_wr = 1'b1; idx_wdata = 7'(v);
    @(posedge clk); #1; idx_wr = 1'b0;
    settle();
  endtask

  task automatic write_set(bit which, int v);
    @(posedge clk); #1;
    set_wdata = 8'(v);
    if (which) set1_wr = 1'b1; else set0_wr = 1'b1;
    @(posedge clk); #1; set0_wr = 1'b0; set1_wr = 1'b0;
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    tag = "R10";
    chk("R10 index", index, 0);
    chk("R10 setting0", setting0, 0);
    chk("R10 tau", tau, 0);
    chk("R10 rd_en", rd_en, 0);

    // R3: preload index 40 in test mode, first reading 39.5 C gives raw step 39
    tag = "R3";
    @(posedge clk); #1 idx_auto = 1'b0;
    write_idx(40);
    @(posedge clk); #1 idx_auto = 1'b1;
    send_temp(632);
    chk("R3 first reading index", index, 39);

    tag = "R4";
    send_temp(400);
    chk("R4 fall lands on hysteresis step", index, 33);
    chk("R5 setting0 at 33", setting0, 234);
    chk("R5 setting1 at 33", setting1, 156);
    send_temp(432);
    chk("R4 27.0 C holds", index, 33);
    send_temp(448);
    chk("R4 rise at 28.0 C", index, 34);
    send_temp(436);
    chk("R4 27.25 C inside band", index, 34);
    send_temp(431);
    chk("R4 fall below 27.0 C", index, 33);

    tag = "R1";
    send_temp(-640);
    chk("R1 -40 C", index, 0);
    send_temp(-608);
    chk("R1 -38 C", index, 1);

    tag = "R2";
    send_temp(-800);
    chk("R2 low clamp", index, 0);
    send_temp(1920);
    chk("R2 high clamp", index, 71);

    tag = "R9";
    @(posedge clk); #1;
    bus_busy = 1'b1; temp_valid = 1'b1; temp_data = 16'(640 * 8);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R9 ready low while busy", temp_ready, 0);
    chk("R9 index held while busy", index, 71);
    @(posedge clk); #1 bus_busy = 1'b0;
    @(posedge clk); #1 temp_valid = 1'b0;
    settle();
    chk("R9 word taken after release", index, 40);

    tag = "R6";
    @(posedge clk); #1 tau_clr = 1'b1;
    @(posedge clk); #1 tau_clr = 1'b0;
    @(negedge clk);
    chk("R6 tau cleared", tau, 0);
    send_temp(480);
    chk("R6 tau set by load", tau, 1);
    chk("R6 index 30 C", index, 35);
    @(posedge clk); #1 tau_clr = 1'b1;
    @(posedge clk); #1 tau_clr = 1'b0;

    tag = "R7";
    @(posedge clk); #1 upd_en = 1'b0;
    send_temp(0);
    chk("R7 index unchanged", index, 35);
    chk("R7 tau unchanged", tau, 0);
    write_set(1'b0, 8'h5A);
    write_set(1'b1, 8'hC3);
    chk("R7 manual setting0", setting0, 8'h5A);
    chk("R7 manual setting1", setting1, 8'hC3);
    @(posedge clk); #1 upd_en = 1'b1;
    write_set(1'b0, 8'h11);
    chk("R7 write ignored when enabled", setting0, 8'h5A);

    tag = "R8";
    @(posedge clk); #1 idx_auto = 1'b0;
    send_temp(-320);
    chk("R8 frozen index", index, 35);
    chk("R8 reload setting0", setting0, 248);
    chk("R8 tau on reload", tau, 1);
    @(posedge clk); #1 tau_clr = 1'b1;
    @(posedge clk); #1 tau_clr = 1'b0;
    write_idx(10);
    chk("R8 written index", index, 10);
    chk("R8 setting0 at 10", setting0, 73);
    chk("R8 setting1 at 10", setting1, 225);
    chk("R8 no tau on index write", tau, 0);
    write_idx(100);
    chk("R8 written index clamped", index, 71);
    chk("R5 setting0 at 71", setting0, 244);
    chk("R5 setting1 at 71", setting1, 42);
    @(posedge clk); #1 idx_auto = 1'b1;
    write_idx(5);
    chk("R8 index write ignored in auto", index, 71);

    settle();
    finish_run();
  end
endmodule